// File: doc/BRIEF.md
# Copper Port Link Bring-Up Sequencer

This block brings one copper Ethernet port from reset to a resolved link state with no software involvement. A pulse on `start` launches the sequence. The block polls the PHY for receive energy, then makes a series of timed link checks. Between failed checks it swaps the cable polarity through a crossover-select output. Once link is up, it reads the negotiated speed and duplex. It then follows the pause-capability chain through the auto-negotiation registers.

Every PHY access is a read through a request/acknowledge management port. The block holds a request and its register number until the management engine acknowledges it, and takes the read data in that same cycle. Millisecond timing comes from a one-cycle prescaled tick input. The block counts whole ticks, so the core clock frequency does not matter.

The result goes into four registered status bits: link, 100 Mb speed, full duplex and pause. A one-cycle `done` pulse marks each update of these bits. When every link check fails, `no_link` is raised and the status is cleared.

Top module: `link_resolver`

## Requirements
- R1: A `start` pulse while idle launches the sequence and raises `busy`. A `start` while busy is ignored and does not restart the sequence.
- R2: Every read holds `mgmt_req` high, with `mgmt_reg` stable and `mgmt_phy` equal to `PHY_ADDR` (default 6), until the cycle in which `mgmt_ack` is high. Only one read is outstanding at a time.
- R3: Signal detection reads register 17 and tests bit 1. Polling stops at the first read with the bit set, or after `SIG_POLLS` reads. The link phase follows in both cases.
- R4: Each link check is a read of register 1 that comes at least `WAIT_MS` ticks of `ms_tick` after the previous read.
- R5: `xover_sel` is 0 for the first link check. It toggles after each failed check that is followed by another check.
- R6: If bit 2 of register 1 is clear on all `LINK_TRIES` checks, the block pulses `done`, sets `no_link`, clears all four status bits and returns to idle.
- R7: When link is found and register 1 bit 5 is set, register 31 is read and its bits 4:2 are decoded. Code 1 gives 10 Mb half duplex, 5 gives 10 Mb full duplex, 2 gives 100 Mb half duplex and 6 gives 100 Mb full duplex. With bit 5 clear, register 31 is not read and speed and duplex stay clear.
- R8: Any other value in bits 4:2 of register 31 leaves both `st_speed` and `st_duplex` clear.
- R9: Pause resolution runs only after register 31 has been read. The block then checks register 1 bit 3, reads register 6 and tests bit 0, reads register 4 and tests bit 10, and reads register 5 and tests bit 10, in that order. The chain stops at the first clear bit. `st_pause` is set only if all four bits are set.
- R10: On success, `done` pulses for exactly one cycle, `st_link` is set, `no_link` is clear, and the status bits hold the result from that cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a bring-up sequence when idle |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| mgmt_req | output | 1 | Read request, held until acknowledged |
| mgmt_phy | output | ADDR_W | PHY address of the read |
| mgmt_reg | output | ADDR_W | Register number of the read |
| mgmt_ack | input | 1 | Read completion; `mgmt_rdata` is valid in this cycle |
| mgmt_rdata | input | DATA_W | Read data |
| xover_sel | output | 1 | Cable polarity select: 0 straight, 1 crossed |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the status bits are updated |
| no_link | output | 1 | All link checks failed in the last sequence |
| st_link | output | 1 | Link up |
| st_speed | output | 1 | 1 = 100 Mb, 0 = 10 Mb or unknown |
| st_duplex | output | 1 | 1 = full duplex |
| st_pause | output | 1 | Pause agreed by both link partners |

## Verification
The hardest case to reach from the ports is a long run of failed link checks: the polarity must alternate on every miss, each miss must follow a full tick wait, and the last miss must end in a cleared status. A close second is a pause chain that stops partway through. The bench uses a programmable PHY responder. Per scenario it sets how many register-17 and register-1 reads fail before succeeding, and it chooses each bit the pause chain tests. It logs every acknowledged read with its register number, the polarity at that moment and a running tick count. The bench checks the read order, the polarity pattern and the wait lengths against that log.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SIG,
    S_WAIT,
    S_LINK,
    S_MODE,
    S_AN6,
    S_AN4,
    S_AN5,
    S_FIN
  } lrs_state_e;

  // PHY register numbers
  localparam int REG_SIGQ = 17;
  localparam int REG_STAT = 1;
  localparam int REG_MODE = 31;
  localparam int REG_ANX  = 6;
  localparam int REG_ADV  = 4;
  localparam int REG_LPA  = 5;

  // bit positions tested
  localparam int B_SIGDET  = 1;
  localparam int B_LINK    = 2;
  localparam int B_ANABLE  = 3;
  localparam int B_NEGDONE = 5;
  localparam int B_LPNEG   = 0;
  localparam int B_PAUSE   = 10;
  localparam int MODE_LSB  = 2;

  // speed/duplex codes
  localparam logic [2:0] C_10H  = 3'd1;
  localparam logic [2:0] C_10F  = 3'd5;
  localparam logic [2:0] C_100H = 3'd2;
  localparam logic [2:0] C_100F = 3'd6;

endpackage

// File: rtl/lrs_rd_port.sv
module lrs_rd_port #(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int PHY_ADDR = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] reg_in,
  input  logic              ack,
  input  logic [DATA_W-1:0] rdata,
  output logic              req,
  output logic [ADDR_W-1:0] phy,
  output logic [ADDR_W-1:0] regad,
  output logic              valid,
  output logic [DATA_W-1:0] data
);

  assign phy = ADDR_W'(PHY_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      req   <= 1'b0;
      regad <= '0;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= 1'b0;
      if (go && !req) begin
        req   <= 1'b1;
        regad <= reg_in;
      end else if (req && ack) begin
        req   <= 1'b0;
        valid <= 1'b1;
        data  <= rdata;
      end
    end
  end

  // R2: request and register number held until acknowledged
  a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
    req && !ack |=> req && $stable(regad));

  // R2: a new read is never launched over an outstanding one
  a_r2_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    go |-> !req);

endmodule

// File: rtl/lrs_ms_timer.sv
module lrs_ms_timer #(
  parameter int WAIT_MS = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick,
  output logic expired
);

  localparam int CW = $clog2(WAIT_MS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(WAIT_MS);
    end else if (tick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // R4: without a reload the count never rises and moves by one at most
  a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
    !load |=> (cnt == $past(cnt)) || (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/lrs_mode_decode.sv
module lrs_mode_decode
  import lrs_pkg::*;
(
  input  logic [2:0] code,
  output logic       fast,
  output logic       full
);

  always_comb begin
    fast = 1'b0;
    full = 1'b0;
    case (code)
      C_10H:   begin fast = 1'b0; full = 1'b0; end
      C_10F:   begin fast = 1'b0; full = 1'b1; end
      C_100H:  begin fast = 1'b1; full = 1'b0; end
      C_100F:  begin fast = 1'b1; full = 1'b1; end
      default: begin fast = 1'b0; full = 1'b0; end
    endcase
  end

  // R8: only a listed code can raise speed or duplex
  always_comb begin
    a_r8_unknown_clear: assert (!(fast || full) || code == C_10F ||
                                code == C_100H || code == C_100F);
  end

endmodule

// File: rtl/link_resolver.sv
module link_resolver
  import lrs_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int PHY_ADDR   = 6,
  parameter int SIG_POLLS  = 100,
  parameter int LINK_TRIES = 100,
  parameter int WAIT_MS    = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ms_tick,
  output logic              mgmt_req,
  output logic [ADDR_W-1:0] mgmt_phy,
  output logic [ADDR_W-1:0] mgmt_reg,
  input  logic              mgmt_ack,
  input  logic [DATA_W-1:0] mgmt_rdata,
  output logic              xover_sel,
  output logic              busy,
  output logic              done,
  output logic              no_link,
  output logic              st_link,
  output logic              st_speed,
  output logic              st_duplex,
  output logic              st_pause
);

  localparam int SIG_CW = $clog2(SIG_POLLS + 1);
  localparam int LNK_CW = $clog2(LINK_TRIES + 1);

  lrs_state_e        state;
  logic              launched;
  logic [SIG_CW-1:0] sig_cnt;
  logic [LNK_CW-1:0] lnk_cnt;
  logic              an_able;
  logic              r_fast, r_full, r_pause;

  logic              rd_go, rd_valid, is_read;
  logic [ADDR_W-1:0] rd_sel;
  logic [DATA_W-1:0] rd_word;
  logic              tmr_load, tmr_expired;
  logic              dec_fast, dec_full;
  logic              unused_bits;

  assign unused_bits = ^rd_word;

  // register selection per read state
  always_comb begin
    is_read = 1'b1;
    case (state)
      S_SIG:   rd_sel = ADDR_W'(REG_SIGQ);
      S_LINK:  rd_sel = ADDR_W'(REG_STAT);
      S_MODE:  rd_sel = ADDR_W'(REG_MODE);
      S_AN6:   rd_sel = ADDR_W'(REG_ANX);
      S_AN4:   rd_sel = ADDR_W'(REG_ADV);
      S_AN5:   rd_sel = ADDR_W'(REG_LPA);
      default: begin rd_sel = '0; is_read = 1'b0; end
    endcase
  end

  assign rd_go    = is_read && !launched;
  assign tmr_load = (state == S_WAIT) && !launched;
  assign busy     = (state != S_IDLE);

  lrs_rd_port #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .PHY_ADDR(PHY_ADDR)
  ) u_rd (
    .clk   (clk),
    .rst   (rst),
    .go    (rd_go),
    .reg_in(rd_sel),
    .ack   (mgmt_ack),
    .rdata (mgmt_rdata),
    .req   (mgmt_req),
    .phy   (mgmt_phy),
    .regad (mgmt_reg),
    .valid (rd_valid),
    .data  (rd_word)
  );

  lrs_ms_timer #(
    .WAIT_MS(WAIT_MS)
  ) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .tick   (ms_tick),
    .expired(tmr_expired)
  );

  lrs_mode_decode u_dec (
    .code(rd_word[MODE_LSB +: 3]),
    .fast(dec_fast),
    .full(dec_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      launched  <= 1'b0;
      sig_cnt   <= '0;
      lnk_cnt   <= '0;
      an_able   <= 1'b0;
      r_fast    <= 1'b0;
      r_full    <= 1'b0;
      r_pause   <= 1'b0;
      xover_sel <= 1'b0;
      done      <= 1'b0;
      no_link   <= 1'b0;
      st_link   <= 1'b0;
      st_speed  <= 1'b0;
      st_duplex <= 1'b0;
      st_pause  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state    <= S_SIG;
            launched <= 1'b0;
            sig_cnt  <= '0;
          end
        end
        S_SIG: begin
          if (!launched) begin
            launched <= 1'b1;
          end else if (rd_valid) begin
            launched <= 1'b0;
            if (rd_word[B_SIGDET] || sig_cnt == SIG_CW'(SIG_POLLS - 1)) begin
              state     <= S_WAIT;
              xover_sel <= 1'b0;
              lnk_cnt   <= '0;
            end else begin
              sig_cnt <= sig_cnt + 1'b1;
            end
          end
        end
        S_WAIT: begin
          if (!launched) begin
            launched <= 1'b1;
          end else if (tmr_expired) begin
            launched <= 1'b0;
            state    <= S_LINK;
          end
        end
        S_LINK: begin
          if (!launched) begin
            launched <= 1'b1;
          end else if (rd_valid) begin
            launched <= 1'b0;
            if (rd_word[B_LINK]) begin
              an_able <= rd_word[B_ANABLE];
              r_fast  <= 1'b0;
              r_full  <= 1'b0;
              r_pause <= 1'b0;
              state   <= rd_word[B_NEGDONE] ? S_MODE : S_FIN;
            end else if (lnk_cnt == LNK_CW'(LINK_TRIES - 1)) begin
              no_link   <= 1'b1;
              st_link   <= 1'b0;
              st_speed  <= 1'b0;
              st_duplex <= 1'b0;
              st_pause  <= 1'b0;
              done      <= 1'b1;
              state     <= S_IDLE;
            end else begin
              xover_sel <= ~xover_sel;
              lnk_cnt   <= lnk_cnt + 1'b1;
              state     <= S_WAIT;
            end
          end
        end
        S_MODE: begin
          if (!launched) begin
            launched <= 1'b1;
          end else if (rd_valid) begin
            launched <= 1'b0;
            r_fast   <= dec_fast;
            r_full   <= dec_full;
            state    <= an_able ? S_AN6 : S_FIN;
          end
        end
        S_AN6: begin
          if (!launched) begin
            launched <= 1'b1;
          end else if (rd_valid) begin
            launched <= 1'b0;
            state    <= rd_word[B_LPNEG] ? S_AN4 : S_FIN;
          end
        end
        S_AN4: begin
          if (!launched) begin
            launched <= 1'b1;
          end else if (rd_valid) begin
            launched <= 1'b0;
            state    <= rd_word[B_PAUSE] ? S_AN5 : S_FIN;
          end
        end
        S_AN5: begin
          if (!launched) begin
            launched <= 1'b1;
          end else if (rd_valid) begin
            launched <= 1'b0;
            r_pause  <= rd_word[B_PAUSE];
            state    <= S_FIN;
          end
        end
        S_FIN: begin
          st_link   <= 1'b1;
          st_speed  <= r_fast;
          st_duplex <= r_full;
          st_pause  <= r_pause;
          no_link   <= 1'b0;
          done      <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10: done lasts a single cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1: an accepted start makes the block busy
  a_r1_start_busy: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy);

  // R6: a failed bring-up leaves every status bit clear
  a_r6_nolink_clear: assert property (@(posedge clk) disable iff (rst)
    no_link |-> !st_link && !st_speed && !st_duplex && !st_pause);

  // R9: pause is only reported alongside link
  a_r9_pause_link: assert property (@(posedge clk) disable iff (rst)
    st_pause |-> st_link);

  // R5: polarity moves only at the start of the link phase or after a check
  a_r5_xover_moves: assert property (@(posedge clk) disable iff (rst)
    !$stable(xover_sel) |-> ($past(state) == S_LINK) || ($past(state) == S_SIG));

endmodule

// File: tb/tb_link_resolver.sv
module tb_link_resolver;

  localparam int CLK_PERIOD = 10;
  localparam int SIGP  = 3;
  localparam int LTRY  = 4;
  localparam int WMS   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic ms_tick = 1'b0;
  logic mgmt_req, mgmt_ack;
  logic [4:0] mgmt_phy, mgmt_reg;
  logic [15:0] mgmt_rdata;
  logic xover_sel, busy, done, no_link, st_link, st_speed, st_duplex, st_pause;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_resolver #(
    .SIG_POLLS (SIGP),
    .LINK_TRIES(LTRY),
    .WAIT_MS   (WMS)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .ms_tick(ms_tick),
    .mgmt_req(mgmt_req), .mgmt_phy(mgmt_phy), .mgmt_reg(mgmt_reg),
    .mgmt_ack(mgmt_ack), .mgmt_rdata(mgmt_rdata),
    .xover_sel(xover_sel), .busy(busy), .done(done), .no_link(no_link),
    .st_link(st_link), .st_speed(st_speed), .st_duplex(st_duplex), .st_pause(st_pause)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // PHY model configuration
  int sig_after, link_after;
  bit cfg_neg, cfg_an, cfg_b6, cfg_b4, cfg_b5;
  logic [2:0] cfg_code;
  int tot17 = 0, tot1 = 0, b17 = 0, b1 = 0;
  int phy_bad = 0;

  // read log
  int logreg [0:255];
  int logx   [0:255];
  int logtk  [0:255];
  int nlog = 0;
  int base = 0;
  int tk = 0;
  int exp_seq [0:15];

  function automatic logic [15:0] phy_val(input int r);
    logic [15:0] v;
    v = '0;
    case (r)
      17: if (tot17 - b17 >= sig_after) v[1] = 1'b1;
      1: begin
        if (tot1 - b1 >= link_after) v[2] = 1'b1;
        v[5] = cfg_neg;
        v[3] = cfg_an;
      end
      31: v[4:2] = cfg_code;
      6:  v[0] = cfg_b6;
      4:  v[10] = cfg_b4;
      5:  v[10] = cfg_b5;
      default: v = '0;
    endcase
    return v;
  endfunction

  // tick generator: one tick every fourth cycle
  int div = 0;
  always @(negedge clk) begin
    if (rst) begin
      ms_tick <= 1'b0;
      div = 0;
    end else begin
      div++;
      if (div == 4) begin
        div = 0;
        ms_tick <= 1'b1;
        tk++;
      end else begin
        ms_tick <= 1'b0;
      end
    end
  end

  // management responder: acknowledges two cycles after a request
  int wcnt = 0;
  always @(negedge clk) begin
    if (rst) begin
      mgmt_ack <= 1'b0;
      mgmt_rdata <= '0;
      wcnt = 0;
    end else if (mgmt_ack) begin
      mgmt_ack <= 1'b0;
    end else if (mgmt_req) begin
      wcnt++;
      if (wcnt >= 2) begin
        wcnt = 0;
        mgmt_ack <= 1'b1;
        mgmt_rdata <= phy_val(int'(mgmt_reg));
        if (mgmt_phy != 5'd6) phy_bad++;
        if (nlog < 256) begin
          logreg[nlog] = int'(mgmt_reg);
          logx[nlog]   = int'(xover_sel);
          logtk[nlog]  = tk;
          nlog++;
        end
        if (mgmt_reg == 5'd17) tot17++;
        if (mgmt_reg == 5'd1) tot1++;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_seq(input string req, input int n);
    chk(req, "read count", nlog - base, n);
    for (int i = 0; i < n; i++)
      if (base + i < nlog) chk(req, $sformatf("read %0d register", i), logreg[base + i], exp_seq[i]);
  endtask

  task automatic chk_status(input string req, input int lk, input int sp, input int dp,
                            input int pa, input int nl);
    chk(req, "st_link", int'(st_link), lk);
    chk(req, "st_speed", int'(st_speed), sp);
    chk(req, "st_duplex", int'(st_duplex), dp);
    chk(req, "st_pause", int'(st_pause), pa);
    chk(req, "no_link", int'(no_link), nl);
  endtask

  // launch, wait for done, check the pulse is one cycle wide (R10)
  task automatic launch_and_wait();
    b17 = tot17;
    b1 = tot1;
    base = nlog;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R1", "busy after start", int'(busy), 1);
    while (!done) @(negedge clk);
  endtask

  task automatic after_done();
    @(negedge clk);
    chk("R10", "done one cycle", int'(done), 0);
    chk("R1", "idle after done", int'(busy), 0);
  endtask

  // R4 / R5: tick spacing and polarity at each register-1 read
  task automatic chk_link_reads(input string req);
    int k;
    k = 0;
    for (int i = base; i < nlog; i++) begin
      if (logreg[i] == 1) begin
        chk("R5", $sformatf("%s xover at check %0d", req, k), logx[i], k % 2);
        if (logtk[i] - logtk[i-1] < WMS || logtk[i] - logtk[i-1] > WMS + 3)
          chk("R4", $sformatf("%s ticks before check %0d", req, k), logtk[i] - logtk[i-1], WMS);
        else
          chk("R4", "tick window", 1, 1);
        k++;
      end
    end
  endtask

  task automatic sc_reset();
    chk("R10", "reset st_link", int'(st_link), 0);
    chk("R1", "reset busy", int'(busy), 0);
    chk("R2", "reset mgmt_req", int'(mgmt_req), 0);
    chk("R10", "reset done", int'(done), 0);
  endtask

  task automatic sc_fast();
    sig_after = 0; link_after = 0;
    cfg_neg = 1; cfg_an = 1; cfg_code = 3'd6; cfg_b6 = 1; cfg_b4 = 1; cfg_b5 = 1;
    launch_and_wait();
    chk_status("R7 R9 R10", 1, 1, 1, 1, 0);
    exp_seq[0] = 17; exp_seq[1] = 1; exp_seq[2] = 31;
    exp_seq[3] = 6; exp_seq[4] = 4; exp_seq[5] = 5;
    chk_seq("R9", 6);
    chk_link_reads("R5 fast");
    after_done();
  endtask

  task automatic sc_nolink();
    sig_after = 0; link_after = 99;
    cfg_neg = 1; cfg_an = 1; cfg_code = 3'd6;
    launch_and_wait();
    chk_status("R6", 0, 0, 0, 0, 1);
    exp_seq[0] = 17;
    for (int i = 1; i <= LTRY; i++) exp_seq[i] = 1;
    chk_seq("R6", LTRY + 1);
    chk_link_reads("R6");
    after_done();
  endtask

  task automatic sc_badcode();
    sig_after = 0; link_after = 0;
    cfg_neg = 1; cfg_an = 1; cfg_code = 3'd7; cfg_b6 = 0;
    launch_and_wait();
    chk_status("R8 R10", 1, 0, 0, 0, 0);
    exp_seq[0] = 17; exp_seq[1] = 1; exp_seq[2] = 31; exp_seq[3] = 6;
    chk_seq("R9", 4);
    after_done();
  endtask

  task automatic sc_retry();
    sig_after = 2; link_after = 2;
    cfg_neg = 1; cfg_an = 0; cfg_code = 3'd1;
    launch_and_wait();
    chk_status("R7", 1, 0, 0, 0, 0);
    exp_seq[0] = 17; exp_seq[1] = 17; exp_seq[2] = 17;
    exp_seq[3] = 1; exp_seq[4] = 1; exp_seq[5] = 1; exp_seq[6] = 31;
    chk_seq("R3", 7);
    chk_link_reads("R4 retry");
    after_done();
  endtask

  task automatic sc_nosig();
    sig_after = 99; link_after = 0;
    cfg_neg = 1; cfg_an = 1; cfg_code = 3'd5; cfg_b6 = 1; cfg_b4 = 0;
    launch_and_wait();
    chk_status("R7", 1, 0, 1, 0, 0);
    for (int i = 0; i < SIGP; i++) exp_seq[i] = 17;
    exp_seq[SIGP] = 1; exp_seq[SIGP+1] = 31; exp_seq[SIGP+2] = 6; exp_seq[SIGP+3] = 4;
    chk_seq("R3", SIGP + 4);
    after_done();
  endtask

  task automatic sc_noneg();
    sig_after = 0; link_after = 0;
    cfg_neg = 0; cfg_an = 1; cfg_code = 3'd6;
    launch_and_wait();
    chk_status("R7", 1, 0, 0, 0, 0);
    exp_seq[0] = 17; exp_seq[1] = 1;
    chk_seq("R7", 2);
    after_done();
  endtask

  task automatic sc_busy_start();
    int ndone;
    sig_after = 0; link_after = 1;
    cfg_neg = 1; cfg_an = 1; cfg_code = 3'd2; cfg_b6 = 1; cfg_b4 = 1; cfg_b5 = 0;
    b17 = tot17; b1 = tot1; base = nlog;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (12) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    chk_status("R7 R9", 1, 1, 0, 0, 0);
    exp_seq[0] = 17; exp_seq[1] = 1; exp_seq[2] = 1; exp_seq[3] = 31;
    exp_seq[4] = 6; exp_seq[5] = 4; exp_seq[6] = 5;
    chk_seq("R1", 7);
    ndone = 0;
    repeat (40) begin
      @(negedge clk);
      if (done) ndone++;
    end
    chk("R1", "extra done after busy start", ndone, 0);
    chk("R1", "busy after run", int'(busy), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    sc_reset();
    sc_fast();
    sc_nolink();
    sc_badcode();
    sc_retry();
    sc_nosig();
    sc_noneg();
    sc_busy_start();
    chk("R2", "reads with wrong PHY address", phy_bad, 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule